// File: doc/BRIEF.md
# Register-Programmed Copy Engine with Local Buffer

This block is a single-channel copy engine. It moves bytes between an external memory reached through a simple request/acknowledge port and a private 4 KiB byte buffer. The buffer appears in the engine's address space as a window starting at 0x40000. Software uses a small register bus to program a source address, a destination address and a byte count. It then writes a command word that picks the direction and, optionally, asks for a completion interrupt.

With direction 0, the source is an external address and the destination lies inside the buffer window. With direction 1, the source lies inside the window and the destination is external. The run bit in the command register stays high while the copy is in progress and clears itself when the copy ends. Software can poll that bit or wait for the interrupt output. The interrupt is held in cause bit 8 of a status register and is cleared through an acknowledge register.

A copy whose buffer side would fall outside the window is refused before any external access is made. One byte moves per external handshake, and addresses rise by one for each byte.

Top module: `dma_copy_engine`

## Requirements
- R1: After reset, every readable register returns 0, the interrupt output is low and no external request is raised.
- R2: The source (0x80) and destination (0x88) registers hold 32 bits and read back as written. The size register (0x90) keeps only bits 11:0, so bits 31:12 read as 0. Unmapped offsets read 0.
- R3: Writing the command register (0x98) with bit 0 set starts a copy. Bit 0 reads 1 until the copy ends and then reads 0. Bit 1 (direction) and bit 2 (interrupt request) read back as written.
- R4: With direction 0, the engine issues read requests (mem_we=0) at source, source+1, and so on, one per handshake. Each byte is stored at buffer offset destination-0x40000 plus its index.
- R5: With direction 1, the engine issues write requests (mem_we=1) at destination, destination+1, and so on. Each carries the byte at buffer offset source-0x40000 plus its index.
- R6: A raised request keeps its address, write flag and write data unchanged until mem_ack is seen.
- R7: A copy that completes with command bit 2 set sets bit 8 of the status register (0xA0) and drives irq high. A copy without bit 2 leaves them unchanged.
- R8: Writing the acknowledge register (0xA8) with bit 8 set clears status bit 8 and irq. A write to that register with bit 8 clear has no effect.
- R9: If the buffer-side start address is below 0x40000, or start plus size exceeds 0x41000, the copy is refused. No request is made, run clears and no interrupt cause is set.
- R10: While run is 1, writes to the source, destination, size and command registers are ignored.
- R11: A copy of size 0 inside the window makes no request, clears run and sets the interrupt cause if requested.
- R12: A one-byte copy at buffer address 0x40FFF, the last byte of the window, is accepted in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | External access request |
| mem_we | output | 1 | 1 = write to external memory, 0 = read |
| mem_addr | output | 32 | External byte address |
| mem_wdata | output | 8 | Byte for external writes |
| mem_ack | input | 1 | External handshake; completes the current request |
| mem_rdata | input | 8 | Byte returned with mem_ack on reads |
| irq | output | 1 | Completion interrupt, high while status bit 8 is set |

## Verification
A wrong byte counter or a wrong buffer offset shows up at the first external handshake. It appears as an address that does not step by one, or as a mismatch in written data on the return trip through the buffer. A stuck run flag or a window check that accepts a bad copy shows up at once as an unexpected external request, or later as a command register that never reads idle. A lost or stuck interrupt cause is visible on irq in the cycle after the copy ends or after the acknowledge write.

// File: rtl/dma_copy_pkg.sv
package dma_copy_pkg;

  localparam logic [7:0] OFS_SRC    = 8'h80;
  localparam logic [7:0] OFS_DST    = 8'h88;
  localparam logic [7:0] OFS_SIZE   = 8'h90;
  localparam logic [7:0] OFS_CMD    = 8'h98;
  localparam logic [7:0] OFS_STATUS = 8'hA0;
  localparam logic [7:0] OFS_ACK    = 8'hA8;

  localparam int CMD_RUN_BIT = 0;
  localparam int CMD_DIR_BIT = 1;
  localparam int CMD_IRQ_BIT = 2;
  localparam int CAUSE_BIT   = 8;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_CHECK = 2'd1,
    ENG_MOVE  = 2'd2
  } eng_state_e;

endpackage

// File: rtl/dma_copy_regs.sv
module dma_copy_regs
  import dma_copy_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [7:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic [SIZE_W-1:0] size,
  output logic              dir,
  output logic              run,
  output logic              start,
  input  logic              eng_done,
  input  logic              eng_abort,
  output logic              irq
);

  logic [ADDR_W-1:0] src_q, src_d;
  logic [ADDR_W-1:0] dst_q, dst_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic              dir_q, dir_d;
  logic              irqen_q, irqen_d;
  logic              run_q, run_d;
  logic              cause_q, cause_d;
  logic              wr_open;

  assign wr_open = wr && !run_q;
  assign start   = wr_open && (addr == OFS_CMD) && wdata[CMD_RUN_BIT];

  always_comb begin
    src_d   = src_q;
    dst_d   = dst_q;
    size_d  = size_q;
    dir_d   = dir_q;
    irqen_d = irqen_q;
    run_d   = run_q;
    cause_d = cause_q;
    if (wr_open) begin
      case (addr)
        OFS_SRC:  src_d  = wdata[ADDR_W-1:0];
        OFS_DST:  dst_d  = wdata[ADDR_W-1:0];
        OFS_SIZE: size_d = wdata[SIZE_W-1:0];
        OFS_CMD: begin
          dir_d   = wdata[CMD_DIR_BIT];
          irqen_d = wdata[CMD_IRQ_BIT];
        end
        default: ;
      endcase
    end
    if (start) begin
      run_d = 1'b1;
    end else if (eng_done || eng_abort) begin
      run_d = 1'b0;
    end
    if (wr && (addr == OFS_ACK) && wdata[CAUSE_BIT]) begin
      cause_d = 1'b0;
    end
    if (eng_done && irqen_q) begin
      cause_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      size_q  <= '0;
      dir_q   <= 1'b0;
      irqen_q <= 1'b0;
      run_q   <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      src_q   <= src_d;
      dst_q   <= dst_d;
      size_q  <= size_d;
      dir_q   <= dir_d;
      irqen_q <= irqen_d;
      run_q   <= run_d;
      cause_q <= cause_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_SRC:    rdata = 32'(src_q);
      OFS_DST:    rdata = 32'(dst_q);
      OFS_SIZE:   rdata = 32'(size_q);
      OFS_CMD: begin
        rdata[CMD_RUN_BIT] = run_q;
        rdata[CMD_DIR_BIT] = dir_q;
        rdata[CMD_IRQ_BIT] = irqen_q;
      end
      OFS_STATUS: rdata[CAUSE_BIT] = cause_q;
      default:    rdata = '0;
    endcase
  end

  assign src  = src_q;
  assign dst  = dst_q;
  assign size = size_q;
  assign dir  = dir_q;
  assign run  = run_q;
  assign irq  = cause_q;

endmodule

// File: rtl/dma_copy_engine_core.sv
module dma_copy_engine_core
  import dma_copy_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                SIZE_W    = 12,
  parameter int                BUF_BYTES = 4096,
  parameter logic [ADDR_W-1:0] BUF_BASE  = 32'h0004_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic [SIZE_W-1:0] size,
  input  logic              dir,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  output logic              buf_we,
  output logic [SIZE_W-1:0] buf_idx,
  output logic              done,
  output logic              abort
);

  localparam logic [ADDR_W:0] WIN_END = {1'b0, BUF_BASE} + (ADDR_W+1)'(BUF_BYTES);

  eng_state_e        state_q, state_d;
  logic [SIZE_W-1:0] cnt_q, cnt_d;
  logic [ADDR_W-1:0] buf_side;
  logic [ADDR_W-1:0] ext_side;
  logic [ADDR_W-1:0] buf_rel;
  logic [ADDR_W:0]   buf_end;
  logic              in_window;
  logic              last_byte;
  logic              hs;

  assign buf_side  = dir ? src : dst;
  assign ext_side  = dir ? dst : src;
  assign buf_rel   = buf_side - BUF_BASE;
  assign buf_end   = {1'b0, buf_side} + (ADDR_W+1)'(size);
  assign in_window = (buf_side >= BUF_BASE) && (buf_end <= WIN_END);
  assign last_byte = (cnt_q == size - 1'b1);
  assign hs        = (state_q == ENG_MOVE) && mem_ack;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done    = 1'b0;
    abort   = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        if (start) begin
          state_d = ENG_CHECK;
          cnt_d   = '0;
        end
      end
      ENG_CHECK: begin
        if (!in_window) begin
          abort   = 1'b1;
          state_d = ENG_IDLE;
        end else if (size == '0) begin
          done    = 1'b1;
          state_d = ENG_IDLE;
        end else begin
          state_d = ENG_MOVE;
        end
      end
      ENG_MOVE: begin
        if (hs) begin
          if (last_byte) begin
            done    = 1'b1;
            state_d = ENG_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign mem_req  = (state_q == ENG_MOVE);
  assign mem_we   = dir;
  assign mem_addr = ext_side + ADDR_W'(cnt_q);
  assign buf_idx  = buf_rel[SIZE_W-1:0] + cnt_q;
  assign buf_we   = hs && !dir;

endmodule

// File: rtl/dma_copy_buffer.sv
module dma_copy_buffer #(
  parameter int BYTES = 4096,
  parameter int IDX_W = $clog2(BYTES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);

  logic [7:0] mem_q [BYTES];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[idx] <= wdata;
    end
  end

  assign rdata = mem_q[idx];

endmodule

// File: rtl/dma_copy_engine.sv
module dma_copy_engine
  import dma_copy_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                BUF_BYTES = 4096,
  parameter logic [ADDR_W-1:0] BUF_BASE  = 32'h0004_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic              irq
);

  localparam int SIZE_W = $clog2(BUF_BYTES);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [ADDR_W-1:0] cfg_src;
  logic [ADDR_W-1:0] cfg_dst;
  logic [SIZE_W-1:0] cfg_size;
  logic              cfg_dir;
  logic              run_flag;
  logic              start_pulse;
  logic              eng_done;
  logic              eng_abort;
  logic              buf_we;
  logic [SIZE_W-1:0] buf_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  dma_copy_regs #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .src       (cfg_src),
    .dst       (cfg_dst),
    .size      (cfg_size),
    .dir       (cfg_dir),
    .run       (run_flag),
    .start     (start_pulse),
    .eng_done  (eng_done),
    .eng_abort (eng_abort),
    .irq       (irq)
  );

  dma_copy_engine_core #(
    .ADDR_W    (ADDR_W),
    .SIZE_W    (SIZE_W),
    .BUF_BYTES (BUF_BYTES),
    .BUF_BASE  (BUF_BASE)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start_pulse),
    .src      (cfg_src),
    .dst      (cfg_dst),
    .size     (cfg_size),
    .dir      (cfg_dir),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .buf_we   (buf_we),
    .buf_idx  (buf_idx),
    .done     (eng_done),
    .abort    (eng_abort)
  );

  dma_copy_buffer #(
    .BYTES (BUF_BYTES),
    .IDX_W (SIZE_W)
  ) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .idx   (buf_idx),
    .wdata (mem_rdata),
    .rdata (mem_wdata)
  );

endmodule

// File: rtl/dma_copy_engine_chk.sv
module dma_copy_engine_chk
  import dma_copy_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              irq,
  input logic              run,
  input logic              dir,
  input logic              reg_wr,
  input logic [7:0]        reg_addr,
  input logic [31:0]       reg_wdata
);

  AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_req |-> run); // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R6

  AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req && mem_ack) |=> (!mem_req || (mem_addr == $past(mem_addr) + 1'b1))); // R4

  AST_WE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_req |-> (mem_we == dir)); // R5

  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(irq) |-> $fell(run)); // R7

  AST_IRQ_CLEAR_BY_ACK: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(irq) |-> $past(reg_wr && (reg_addr == OFS_ACK) && reg_wdata[CAUSE_BIT])); // R8

endmodule

bind dma_copy_engine dma_copy_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sync_n),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .irq       (irq),
  .run       (run_flag),
  .dir       (cfg_dir),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata)
);

// File: tb/dma_copy_engine_tb.sv
module dma_copy_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam logic [31:0] WIN_BASE = 32'h0004_0000;
  localparam logic [32:0] WIN_END  = 33'h0_0004_1000;

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [7:0]  data;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack;
  logic [7:0]  mem_rdata;
  logic        irq;

  int          n_checks;
  int          n_fail;
  int          cycles;
  int          hs_count;
  int          hold_err;
  bit          finished;
  bit          irq_model;
  logic [7:0]  shadow [4096];
  exp_t        expq [$];
  logic [7:0]  lfsr;
  int          wait_left;
  logic        prev_wait;
  logic [31:0] prev_addr;

  dma_copy_engine u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return 8'(a * 13 + (a >> 8) + 5);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // external memory model and scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack   = 1'b0;
      mem_rdata = 8'h00;
      wait_left = 0;
      prev_wait = 1'b0;
    end else if (mem_ack) begin
      mem_ack   = 1'b0;
      prev_wait = 1'b0;
    end else if (mem_req) begin
      if (prev_wait && (mem_addr != prev_addr)) hold_err++;
      prev_addr = mem_addr;
      if (wait_left == 0) begin
        hs_count++;
        if (expq.size() == 0) begin
          check(1'b0, "R4/R5/R9 unexpected request", mem_addr, 32'hFFFF_FFFF);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(mem_we == e.we && mem_addr == e.addr && (!e.we || mem_wdata == e.data),
                e.we ? "R5 write beat" : "R4 read beat",
                {mem_addr[23:0], mem_wdata}, {e.addr[23:0], e.data});
        end
        mem_rdata = pat(mem_addr);
        mem_ack   = 1'b1;
        prev_wait = 1'b0;
        lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        wait_left = int'(lfsr[1:0]);
      end else begin
        wait_left--;
        prev_wait = 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      reg_read(8'h98, v);
      if (!v[0]) break;
    end
  endtask

  // driver: programs a copy and pushes the expected external beats
  task automatic run_copy(input logic [31:0] src, input logic [31:0] dst,
                          input int size, input logic [2:0] cmd, input bit poke);
    logic [31:0] bside;
    logic [32:0] bend;
    bit          ok;
    int          hs0;
    logic [31:0] v;
    bside = cmd[1] ? src : dst;
    bend  = {1'b0, bside} + 33'(size);
    ok    = (bside >= WIN_BASE) && (bend <= WIN_END);
    reg_write(8'h80, src);
    reg_write(8'h88, dst);
    reg_write(8'h90, 32'(size));
    if (ok) begin
      for (int i = 0; i < size; i++) begin
        exp_t e;
        if (!cmd[1]) begin
          e.we = 1'b0; e.addr = src + 32'(i); e.data = 8'h00;
          shadow[12'(dst - WIN_BASE + 32'(i))] = pat(src + 32'(i));
        end else begin
          e.we = 1'b1; e.addr = dst + 32'(i);
          e.data = shadow[12'(src - WIN_BASE + 32'(i))];
        end
        expq.push_back(e);
      end
      if (cmd[2]) irq_model = 1'b1;
    end
    hs0 = hs_count;
    reg_write(8'h98, {29'd0, cmd});
    if (poke) begin
      reg_read(8'h98, v);
      check(v[0] == 1'b1, "R3 run bit reads 1 while busy", v, 32'h1);
      reg_write(8'h80, 32'h0000_0055);  // R10 ignored while running
      reg_write(8'h90, 32'h0000_0003);
      reg_write(8'h98, 32'h0000_0000);
    end
    wait_idle();
    check(expq.size() == 0, "R4/R5 all beats seen", 32'(expq.size()), 32'd0);
    if (!ok || size == 0) begin
      check(hs_count == hs0, ok ? "R11 no request for size 0" : "R9 no request when refused",
            32'(hs_count - hs0), 32'd0);
    end
    @(negedge clk);
    check(irq == irq_model, "R7/R9/R11 irq after copy", 32'(irq), 32'(irq_model));
  endtask

  initial begin
    logic [31:0] v;
    n_checks = 0; n_fail = 0; cycles = 0; hs_count = 0; hold_err = 0;
    finished = 1'b0; irq_model = 1'b0; lfsr = 8'hA5;
    reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 32'h0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    reg_read(8'h80, v); check(v == 0, "R1 src after reset", v, 0);
    reg_read(8'h90, v); check(v == 0, "R1 size after reset", v, 0);
    reg_read(8'h98, v); check(v == 0, "R1 cmd after reset", v, 0);
    reg_read(8'hA0, v); check(v == 0, "R1 status after reset", v, 0);
    check(irq == 1'b0 && mem_req == 1'b0, "R1 outputs idle", {irq, mem_req}, 0);

    // R2 readback and size truncation
    reg_write(8'h80, 32'hDEAD_BEEF);
    reg_read(8'h80, v); check(v == 32'hDEAD_BEEF, "R2 src readback", v, 32'hDEAD_BEEF);
    reg_write(8'h88, 32'h1234_5678);
    reg_read(8'h88, v); check(v == 32'h1234_5678, "R2 dst readback", v, 32'h1234_5678);
    reg_write(8'h90, 32'hFFFF_F123);
    reg_read(8'h90, v); check(v == 32'h0000_0123, "R2 size keeps 12 bits", v, 32'h123);
    reg_read(8'h44, v); check(v == 0, "R2 unmapped reads 0", v, 0);

    // R4 external to buffer, polled, with mid-run pokes (R10)
    run_copy(32'h0000_1000, 32'h0004_0010, 20, 3'b001, 1'b1);
    reg_read(8'h80, v); check(v == 32'h0000_1000, "R10 src unchanged", v, 32'h1000);
    reg_read(8'h90, v); check(v == 32'd20, "R10 size unchanged", v, 20);
    reg_read(8'h98, v); check(v == 32'h0, "R3 cmd idle after finish", v, 0);

    // R5 buffer to external with interrupt (R7)
    run_copy(32'h0004_0010, 32'h0000_2000, 20, 3'b111, 1'b1);
    reg_read(8'h98, v); check(v == 32'h6, "R3 dir and irq bits read back", v, 6);
    reg_read(8'hA0, v); check(v == 32'h100, "R7 status cause bit 8", v, 32'h100);

    // R8 acknowledge
    reg_write(8'hA8, 32'h0000_00FF);
    @(negedge clk); check(irq == 1'b1, "R8 ack without bit 8 ignored", irq, 1);
    reg_write(8'hA8, 32'h0000_0100);
    @(negedge clk); check(irq == 1'b0, "R8 ack clears irq", irq, 0);
    irq_model = 1'b0;
    reg_read(8'hA0, v); check(v == 0, "R8 status cleared", v, 0);

    // R9 refused copies
    run_copy(32'h0000_3000, 32'h0003_FFFF, 4, 3'b101, 1'b0);
    run_copy(32'h0000_3000, 32'h0004_0FFE, 4, 3'b101, 1'b0);
    run_copy(32'h0004_1000, 32'h0000_5000, 1, 3'b111, 1'b0);

    // R12 last byte of window both ways
    run_copy(32'h0000_3000, 32'h0004_0FFF, 1, 3'b001, 1'b0);
    run_copy(32'h0004_0FFF, 32'h0000_5000, 1, 3'b011, 1'b0);

    // R11 zero-length copy with interrupt
    run_copy(32'h0000_6000, 32'h0004_0000, 0, 3'b101, 1'b0);
    reg_write(8'hA8, 32'h0000_0100);
    irq_model = 1'b0;

    // longer round trip, both directions
    run_copy(32'h0001_0000, 32'h0004_0800, 300, 3'b001, 1'b0);
    run_copy(32'h0004_0800, 32'h0002_0000, 300, 3'b011, 1'b0);

    check(hold_err == 0, "R6 request held until ack", 32'(hold_err), 0);

    finished = 1'b1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule